// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent 16-bit count engines. Each engine is made of a low byte and a high byte. Each engine counts either machine cycles or falling edges on its own count pin. A machine cycle lasts a fixed number of clock cycles, twelve by default. Each engine has a gate pin. When the gate bit is set, the engine counts only while that pin is high, which allows the width of a pulse to be measured.

Two mode bits per engine select the count structure:
- a 13-bit counter, in which the low five bits of the low byte act as a prescaler;
- a full 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split arrangement, in which engine 0 becomes two 8-bit counters and engine 1 stops.

When engine 0 is split, its high byte borrows the run bit and the overflow flag of engine 1. Engine 1 then runs without a flag and only drives its rollover pulse, which other logic can use as a rate source.

Software reaches the block through a plain byte-wide register bus. Writes are synchronous and reads are combinational. A rollover sets a sticky flag. The flag stays set until software writes zero to it.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00, both flag outputs are low and no rollover pulse is driven.
- R2: An engine advances only while its run bit is 1 and either its gate bit is 0 or its gate pin is high. Otherwise its low byte holds.
- R3: In timer mode (select bit 0) an engine advances by exactly one for every TICK_DIV (12) clock cycles while enabled.
- R4: In counter mode (select bit 1) the count pin is sampled once per machine cycle. A high sample followed by a low sample adds exactly one.
- R5: Mode 0 (mode bits 00) uses low-byte bits [4:0] as a prescaler. When they wrap, the high byte increments. Low-byte bits [7:5] never change by counting. The flag is set when the high byte and the prescaler are both all ones and wrap together.
- R6: Mode 1 (mode bits 01) counts {high, low} as one 16-bit value, with the carry going from low into high.
- R7: A rollover to zero sets the engine's flag. The flag stays set until a bus write puts 0 in its control bit.
- R8: In mode 2 (mode bits 10) only the low byte counts. On rollover it loads the high byte's current value. Counting never changes the high byte, and the high byte may be rewritten while the engine runs.
- R9: With engine 0 in mode 3, its low byte counts with engine 0's gate, select, run bit and flag. Its high byte counts machine cycles only, under engine 1's run bit, and its rollover sets flag 1.
- R10: While engine 0 is in mode 3, engine 1 counts whenever its gate condition allows, whatever its run bit. Its rollover drives t1_ovf_pulse_o but does not set flag 1.
- R11: Engine 1 in mode 3 holds both of its bytes.
- R12: Register map, 3-bit address:
  - 0: mode. Bits [3:0] belong to engine 0 and bits [7:4] to engine 1. Within each nibble: bit 3 gate, bit 2 select, bits [1:0] mode.
  - 1: control. Bit 0 run0, bit 1 flag0, bit 2 run1, bit 3 flag1; bits [7:4] read as 0.
  - 2, 3: engine 0 low and high byte.
  - 4, 5: engine 1 low and high byte.
  - 6, 7: read as 0.
- R13: A bus write to a count byte replaces that byte on the same edge. The other byte of the same engine keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| cnt_pin_i | input | 2 | External count pins, one per engine |
| gate_pin_i | input | 2 | Gate pins, one per engine |
| ovf_flag_o | output | 2 | Sticky overflow flags: bit 0 engine 0, bit 1 engine 1 |
| t1_ovf_pulse_o | output | 1 | One-cycle pulse in the cycle before engine 1 wraps |

## Verification
Each count lands on the clock edge where the machine-cycle tick is high, and the flag sets on that same edge. The rollover pulse is high in the cycle before that edge, and register reads appear in the same cycle as the address.

The tick phase after reset is not assumed. Instead, each count check starts the engine with a bus write on one edge and then waits an exact multiple of 12 edges. It samples at the following falling edge. Any window of 12·N consecutive edges holds exactly N ticks, so the expected value depends only on N.

Tests that need a write to hit between two particular ticks place the write at least a full machine cycle away from the tick that the check depends on.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    M_13     = 2'd0,
    M_16     = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmr_mode_e;

  // gate at nibble bit 3, select at bit 2, mode at [1:0]
  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_pair_tick.sv
module tmr_pair_tick #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/tmr_pair_evt.sv
module tmr_pair_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_sel_i,
  input  logic gate_i,
  input  logic run_i,
  input  logic gate_pin_i,
  input  logic cnt_pin_i,
  output logic evt_o
);
  logic smp_q;
  logic fall;
  logic en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smp_q <= 1'b0;
    else if (tick_i) smp_q <= cnt_pin_i;
  end

  // previous sample high, this sample low
  assign fall  = smp_q & ~cnt_pin_i;
  assign en    = run_i & (~gate_i | gate_pin_i);
  assign evt_o = en & tick_i & (ext_sel_i ? fall : 1'b1);
endmodule

// File: rtl/tmr_pair_core.sv
module tmr_pair_core
  import tmr_pair_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b1,
  parameter int PRE_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              cnt_evt_i,
  input  logic              hi_evt_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              hi_ovf_o
);
  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    unique case (mode_i)
      M_13: if (cnt_evt_i) begin
        lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
        if (&lo_q[PRE_W-1:0]) begin
          hi_d  = hi_q + BYTE_W'(1);
          ovf_o = &hi_q;
        end
      end
      M_16: if (cnt_evt_i) begin
        {hi_d, lo_d} = {hi_q, lo_q} + CW'(1);
        ovf_o        = &{hi_q, lo_q};
      end
      M_RELOAD: if (cnt_evt_i) begin
        if (&lo_q) begin
          lo_d  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_d = lo_q + BYTE_W'(1);
        end
      end
      M_SPLIT: if (SPLIT_OK) begin
        if (cnt_evt_i) begin
          lo_d  = lo_q + BYTE_W'(1);
          ovf_o = &lo_q;
        end
        if (hi_evt_i) begin
          hi_d     = hi_q + BYTE_W'(1);
          hi_ovf_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int PRE_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  output logic [1:0]        ovf_flag_o,
  output logic              t1_ovf_pulse_o
);
  localparam int NT = 2;

  tmr_cfg_t [NT-1:0]             cfg_q;
  logic     [NT-1:0]             run_q, flag_q, flag_set;
  logic     [NT-1:0]             run_eff, evt, ovf, hi_ovf, wr_lo, wr_hi;
  logic     [NT-1:0][BYTE_W-1:0] lo, hi;
  logic                          tick, split0, split_evt, wr_mode, wr_ctrl;

  assign wr_mode = bus_we_i && (bus_addr_i == A_MODE);
  assign wr_ctrl = bus_we_i && (bus_addr_i == A_CTRL);

  tmr_pair_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign split0     = (cfg_q[0].mode == M_SPLIT);
  // engine 1 loses its run bit to engine 0's high byte while split
  assign run_eff[0] = run_q[0];
  assign run_eff[1] = split0 | run_q[1];
  assign split_evt  = tick & run_q[1];

  for (genvar i = 0; i < NT; i++) begin : g_eng
    assign wr_lo[i] = bus_we_i && (bus_addr_i == ADDR_W'(A_LO0 + 2 * i));
    assign wr_hi[i] = bus_we_i && (bus_addr_i == ADDR_W'(A_HI0 + 2 * i));

    tmr_pair_evt u_evt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .ext_sel_i  (cfg_q[i].ext),
      .gate_i     (cfg_q[i].gate),
      .run_i      (run_eff[i]),
      .gate_pin_i (gate_pin_i[i]),
      .cnt_pin_i  (cnt_pin_i[i]),
      .evt_o      (evt[i])
    );

    tmr_pair_core #(.SPLIT_OK(i == 0), .PRE_W(PRE_W)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (cfg_q[i].mode),
      .cnt_evt_i (evt[i]),
      .hi_evt_i  ((i == 0) ? split_evt : 1'b0),
      .wr_lo_i   (wr_lo[i]),
      .wr_hi_i   (wr_hi[i]),
      .wdata_i   (bus_wdata_i),
      .lo_o      (lo[i]),
      .hi_o      (hi[i]),
      .ovf_o     (ovf[i]),
      .hi_ovf_o  (hi_ovf[i])
    );
  end

  assign flag_set[0] = ovf[0];
  assign flag_set[1] = split0 ? hi_ovf[0] : (ovf[1] | hi_ovf[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_mode) cfg_q <= bus_wdata_i;
      if (wr_ctrl) run_q <= {bus_wdata_i[2], bus_wdata_i[0]};
      // hardware set wins over a same-cycle software clear
      flag_q <= (wr_ctrl ? {bus_wdata_i[3], bus_wdata_i[1]} : flag_q) | flag_set;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_MODE:  bus_rdata_o = cfg_q;
      A_CTRL:  bus_rdata_o = {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
      A_LO0:   bus_rdata_o = lo[0];
      A_HI0:   bus_rdata_o = hi[0];
      A_LO1:   bus_rdata_o = lo[1];
      A_HI1:   bus_rdata_o = hi[1];
      default: bus_rdata_o = '0;
    endcase
  end

  assign ovf_flag_o     = flag_q;
  assign t1_ovf_pulse_o = ovf[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pair_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [1:0]        ovf_flag_o,
  input logic              tick_i,
  input logic [7:0]        cfg_i,
  input logic [1:0]        run_i,
  input logic [BYTE_W-1:0] lo0_i,
  input logic [BYTE_W-1:0] hi0_i,
  input logic [BYTE_W-1:0] lo1_i,
  input logic [BYTE_W-1:0] hi1_i
);
  logic wr_t0, wr_t1;

  assign wr_t0 = bus_we_i && (bus_addr_i == A_LO0 || bus_addr_i == A_HI0);
  assign wr_t1 = bus_we_i && (bus_addr_i == A_LO1 || bus_addr_i == A_HI1);

  p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o[0] && !(bus_we_i && bus_addr_i == A_CTRL)) |=> ovf_flag_o[0]);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] && !(bus_we_i && bus_addr_i == A_LO0)) |=> $stable(lo0_i));

  p_tick_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_t0) |=> ($stable(lo0_i) && $stable(hi0_i)));

  p_hold_t1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[5:4] == 2'd3 && !wr_t1) |=> ($stable(lo1_i) && $stable(hi1_i)));

  p_reload_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1:0] == 2'd2 && !(bus_we_i && bus_addr_i == A_HI0)) |=> $stable(hi0_i));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .ovf_flag_o (ovf_flag_o),
  .tick_i     (tick),
  .cfg_i      (cfg_q),
  .run_i      (run_q),
  .lo0_i      (lo[0]),
  .hi0_i      (hi[0]),
  .lo1_i      (lo[1]),
  .hi1_i      (hi[1])
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] flags;
  logic       t1_pulse;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bus_we_i       (we),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .cnt_pin_i      (cnt_pin),
    .gate_pin_i     (gate_pin),
    .ovf_flag_o     (flags),
    .t1_ovf_pulse_o (t1_pulse)
  );

  always @(negedge clk) if (rst_n && t1_pulse) pulses++;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] n;
    logic [7:0] exp_hi;
    logic [7:0] exp_lo;
    logic       exp_flag;
  } vec_t;

  // engine 0, gated by pin (high), timer mode; n machine cycles
  localparam vec_t VECS [7] = '{
    '{2'd1, 8'h00, 8'h00, 8'd5,  8'h00, 8'h05, 1'b0},  // R6
    '{2'd1, 8'h00, 8'hFE, 8'd3,  8'h01, 8'h01, 1'b0},  // R6 carry
    '{2'd1, 8'hFF, 8'hFE, 8'd3,  8'h00, 8'h01, 1'b1},  // R6 R7
    '{2'd0, 8'h00, 8'hE0, 8'd33, 8'h01, 8'hE1, 1'b0},  // R5 top bits kept
    '{2'd0, 8'hFF, 8'h1E, 8'd3,  8'h00, 8'h01, 1'b1},  // R5 R7
    '{2'd2, 8'hF0, 8'hFE, 8'd4,  8'hF0, 8'hF2, 1'b1},  // R8 reload
    '{2'd2, 8'h80, 8'h10, 8'd6,  8'h80, 8'h16, 1'b0}   // R8
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_mc(input int n);
    repeat (12 * n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      rd(3'(r), v);
      chk("R1 reg", {8'h0, v}, 16'h0);
    end
    chk("R1 flags", {14'h0, flags}, 16'h0);
    chk("R1 pulse", {15'h0, t1_pulse}, 16'h0);

    // R12 map readback
    wr(3'd0, 8'h3C); rd(3'd0, v); chk("R12 mode", {8'h0, v}, 16'h003C);
    wr(3'd4, 8'h5A); rd(3'd4, v); chk("R12 lo1", {8'h0, v}, 16'h005A);
    wr(3'd5, 8'hC3); rd(3'd5, v); chk("R12 hi1", {8'h0, v}, 16'h00C3);
    rd(3'd6, v); chk("R12 unused", {8'h0, v}, 16'h0);

    // table walk
    gate_pin = 2'b01;
    foreach (VECS[k]) begin
      wr(3'd1, 8'h00);
      wr(3'd0, {6'b000010, VECS[k].mode});
      wr(3'd2, VECS[k].lo);
      wr(3'd3, VECS[k].hi);
      wr(3'd1, 8'h01);
      wait_mc(int'(VECS[k].n));
      rd(3'd2, a0); rd(3'd3, b0);
      chk("R5/R6/R8 lo", {8'h0, a0}, {8'h0, VECS[k].exp_lo});
      chk("R5/R6/R8 hi", {8'h0, b0}, {8'h0, VECS[k].exp_hi});
      chk("R7 flag0", {15'h0, flags[0]}, {15'h0, VECS[k].exp_flag});
    end

    // R7 flag stays until written to 0
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    wait_mc(3);
    chk("R7 set", {15'h0, flags[0]}, 16'h1);
    wr(3'd1, 8'h02);  // run off, flag kept
    wait_mc(2);
    chk("R7 sticky", {15'h0, flags[0]}, 16'h1);
    wr(3'd1, 8'h00);
    chk("R7 clear", {15'h0, flags[0]}, 16'h0);

    // R2 run bit off
    gate_pin = 2'b00;
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wait_mc(4);
    rd(3'd2, v); chk("R2 run off", {8'h0, v}, 16'h0);
    // R2 gate set, pin low
    wr(3'd0, 8'h09); wr(3'd1, 8'h01);
    wait_mc(4);
    rd(3'd2, v); chk("R2 gate low", {8'h0, v}, 16'h0);

    // R3 free-running rate
    wr(3'd0, 8'h01);
    @(negedge clk); rd(3'd2, a0);
    repeat (120) @(negedge clk);
    rd(3'd2, b0);
    chk("R3 rate", {8'h0, 8'(b0 - a0)}, 16'd10);

    // R4 counter mode
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin[0] = 1'b0;
    wr(3'd1, 8'h01);
    for (int p = 0; p < 3; p++) begin
      cnt_pin[0] = 1'b1; repeat (36) @(negedge clk);
      cnt_pin[0] = 1'b0; repeat (36) @(negedge clk);
    end
    rd(3'd2, v); chk("R4 edges", {8'h0, v}, 16'd3);
    cnt_pin[0] = 1'b1; repeat (36) @(negedge clk);
    rd(3'd2, v); chk("R4 rising ignored", {8'h0, v}, 16'd3);
    cnt_pin[0] = 1'b0;

    // R8 R13 high byte rewrite while running
    wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'hFD); wr(3'd3, 8'h10);
    wr(3'd1, 8'h01);
    repeat (11) @(posedge clk);
    @(negedge clk);
    wr(3'd3, 8'h20);  // lands on edge 13 after start
    repeat (23) @(posedge clk);
    @(negedge clk);
    rd(3'd2, a0); rd(3'd3, b0);
    chk("R8 R13 reload new", {8'h0, a0}, 16'h0020);
    chk("R8 hi kept", {8'h0, b0}, 16'h0020);

    // R9 split: high byte on run1, flag1
    wr(3'd1, 8'h00); wr(3'd0, 8'h0B); wr(3'd2, 8'h00); wr(3'd3, 8'hFE);
    gate_pin = 2'b00;
    wr(3'd1, 8'h04);
    wait_mc(3);
    rd(3'd2, a0); rd(3'd3, b0);
    chk("R9 hi", {8'h0, b0}, 16'h0001);
    chk("R9 lo gated", {8'h0, a0}, 16'h0000);
    chk("R9 flag1", {14'h0, flags}, 16'h2);

    // R10 engine 1 during split
    wr(3'd1, 8'h00); wr(3'd0, 8'h11); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    pulses = 0;
    wr(3'd0, 8'h13);
    wait_mc(3);
    rd(3'd4, a0); rd(3'd5, b0);
    chk("R10 count", {b0, a0}, 16'h0001);
    chk("R10 no flag", {14'h0, flags}, 16'h0);
    chk("R10 pulse", 16'(pulses), 16'd1);

    // R7 R10 normal engine 1 rollover
    wr(3'd0, 8'h11); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulses = 0;
    wr(3'd1, 8'h04);
    wait_mc(1);
    chk("R7 flag1", {15'h0, flags[1]}, 16'h1);
    chk("R10 pulse normal", 16'(pulses), 16'd1);

    // R11 engine 1 in mode 3 holds
    wr(3'd1, 8'h00); wr(3'd0, 8'h31); wr(3'd4, 8'h40); wr(3'd5, 8'h00);
    wr(3'd1, 8'h04);
    wait_mc(3);
    rd(3'd4, v); chk("R11 hold", {8'h0, v}, 16'h0040);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule